// File: doc/BRIEF.md
# Reversible Five-Digit Ring Display

This block steps through a fixed ring of five decimal digits and shows the current one on a single seven-segment display. The segments are active low. The five digit values are parameters.

A press of an active-low step button moves the ring one place. The move goes forward or backward, as chosen by a direction level. That level may be changed between any two presses.

The step button is brought into the system clock domain through a two-flop synchronizer. A falling edge on the synchronized level makes a one-cycle advance event. An active-low reset button returns the ring to the first digit on the next rising clock edge, and it overrides an advance event in the same cycle.

Top module: `digit_ring_display`

## Requirements
- R1: When `rst_btn_n` is sampled 0 at a rising edge, `seg_n` shows digit 0 (`DIG0`) after that edge, whatever the value of `dir_fwd`.
- R2: The ring has exactly five positions, 0 to 4, holding `DIG0`..`DIG4`. With `dir_fwd`=1, each step moves from position i to i+1, and from position 4 to position 0.
- R3: With `dir_fwd`=0, each step moves from position i to i-1, and from position 0 to position 4. The display order after reset is therefore `DIG0`, `DIG4`, `DIG3`, `DIG2`, `DIG1`, `DIG0`.
- R4: `dir_fwd` is sampled at each step on its own. Changing it between steps reverses the walk from the current position.
- R5: One press gives exactly one step, however long `step_btn_n` is held low. Releasing the button causes no step.
- R6: If `step_btn_n` is first sampled 0 at rising edge k, the display is unchanged after edges k and k+1 and shows the new digit after edge k+2.
- R7: If reset and an advance event fall in the same cycle, reset wins and the ring is at position 0. A button held low through the release of reset causes no further step.
- R8: `seg_n` bit 0 drives segment a and bit 6 drives segment g. A bit of 0 lights its segment. Digits 0..9 use the standard patterns. Any digit value above 9 gives 7'h7F (all segments dark).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| step_btn_n | input | 1 | Step pushbutton, 0 while pressed, asynchronous to `clk` |
| rst_btn_n | input | 1 | Reset pushbutton, 0 while pressed, sampled synchronously |
| dir_fwd | input | 1 | 1 walks the ring forward, 0 walks it backward |
| seg_n | output | 7 | Segment drive {g,f,e,d,c,b,a}, active low |

## Verification
A wrong ring position shows at once on `seg_n`, because the display is decoded combinationally from the position register. A bad step therefore appears in the cycle right after the edge that commits it, two edges after the press is first sampled. A lost or doubled advance event shifts every later digit by one place. Since direction is mixed at random, such a shift is caught on the very next press. A position that escapes the five legal codes shows as a dark display and returns to digit 0 on the next step.

// File: rtl/digit_ring_pkg.sv
package digit_ring_pkg;

  localparam int RING_LEN = 5;
  localparam int POS_W    = $clog2(RING_LEN);

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [3:0]       digit_t;
  typedef logic [6:0]       seg_t;

  // Successor position on the ring; illegal codes fall back to position 0.
  function automatic pos_t ring_next(input pos_t cur, input logic fwd);
    pos_t nxt;
    if (int'(cur) >= RING_LEN)
      nxt = '0;
    else if (fwd)
      nxt = (int'(cur) == RING_LEN - 1) ? pos_t'(0) : pos_t'(cur + pos_t'(1));
    else
      nxt = (cur == pos_t'(0)) ? pos_t'(RING_LEN - 1) : pos_t'(cur - pos_t'(1));
    return nxt;
  endfunction

  // Active-high segment pattern {g,f,e,d,c,b,a}; non-decimal values are dark.
  function automatic seg_t digit_glyph(input digit_t d);
    seg_t g;
    case (d)
      4'd0:    g = 7'b0111111;
      4'd1:    g = 7'b0000110;
      4'd2:    g = 7'b1011011;
      4'd3:    g = 7'b1001111;
      4'd4:    g = 7'b1100110;
      4'd5:    g = 7'b1101101;
      4'd6:    g = 7'b1111101;
      4'd7:    g = 7'b0000111;
      4'd8:    g = 7'b1111111;
      4'd9:    g = 7'b1101111;
      default: g = 7'b0000000;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/step_pulse_gen.sv
module step_pulse_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic pulse
);
  localparam int CHAIN_LEN = SYNC_STAGES + 1;

  logic [CHAIN_LEN-1:0] chain;

  // Synchronizer stages plus one history flop; no reset so a held button
  // never looks like a fresh press once reset is released.
  genvar gi;
  generate
    for (gi = 0; gi < CHAIN_LEN; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) chain[gi] <= btn_n;
      end else begin : g_next
        always_ff @(posedge clk) chain[gi] <= chain[gi-1];
      end
    end
  endgenerate

  logic level_now, level_prev;
  assign level_now  = chain[SYNC_STAGES-1];
  assign level_prev = chain[SYNC_STAGES];
  assign pulse      = level_prev & ~level_now;

  // R5: an advance event never lasts two cycles
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

endmodule

// File: rtl/ring_position_fsm.sv
module ring_position_fsm
  import digit_ring_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic fwd,
  output pos_t pos
);
  pos_t pos_nxt;

  always_comb begin
    pos_nxt = pos;
    if (adv) pos_nxt = ring_next(pos, fwd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pos <= '0;
    else        pos <= pos_nxt;
  end

  // R1 / R7: reset lands on position 0 regardless of advance or direction
  assert_reset_home_R1: assert property (@(posedge clk)
    !rst_n |=> pos == '0);

  // R2: the position stays inside the five-entry ring
  assert_pos_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos) < RING_LEN);

  // R2: forward step and wrap
  assert_fwd_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && fwd && int'(pos) < RING_LEN - 1) |=> pos == pos_t'($past(pos) + pos_t'(1)));
  assert_fwd_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && fwd && int'(pos) == RING_LEN - 1) |=> pos == '0);

  // R3: backward step and wrap
  assert_bwd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !fwd && pos != '0 && int'(pos) < RING_LEN) |=> pos == pos_t'($past(pos) - pos_t'(1)));
  assert_bwd_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !fwd && pos == '0) |=> int'(pos) == RING_LEN - 1);

  // R5: without an advance event the position holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pos));

endmodule

// File: rtl/seven_seg_encoder.sv
module seven_seg_encoder
  import digit_ring_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  digit_t digit,
  output seg_t   seg
);
  seg_t glyph;
  assign glyph = digit_glyph(digit);

  generate
    if (ACTIVE_LOW) begin : g_low
      assign seg = ~glyph;
    end else begin : g_high
      assign seg = glyph;
    end
  endgenerate

  // R8: every decimal digit lights between two and seven segments
  always_comb begin
    if (digit <= 4'd9)
      assert_lit_count_R8: assert ($countones(glyph) >= 2);
  end

endmodule

// File: rtl/digit_ring_display.sv
module digit_ring_display
  import digit_ring_pkg::*;
#(
  parameter logic [3:0] DIG0 = 4'd3,
  parameter logic [3:0] DIG1 = 4'd9,
  parameter logic [3:0] DIG2 = 4'd5,
  parameter logic [3:0] DIG3 = 4'd0,
  parameter logic [3:0] DIG4 = 4'd7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       step_btn_n,
  input  logic       rst_btn_n,
  input  logic       dir_fwd,
  output logic [6:0] seg_n
);
  localparam digit_t DIGS [RING_LEN] = '{DIG0, DIG1, DIG2, DIG3, DIG4};

  logic   step_evt;
  pos_t   ring_pos;
  digit_t cur_digit;

  step_pulse_gen #(.SYNC_STAGES(SYNC_STAGES)) u_step (
    .clk   (clk),
    .rst_n (rst_btn_n),
    .btn_n (step_btn_n),
    .pulse (step_evt)
  );

  ring_position_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_btn_n),
    .adv   (step_evt),
    .fwd   (dir_fwd),
    .pos   (ring_pos)
  );

  assign cur_digit = (int'(ring_pos) < RING_LEN) ? DIGS[ring_pos] : 4'hF;

  seven_seg_encoder #(.ACTIVE_LOW(1'b1)) u_enc (
    .digit (cur_digit),
    .seg   (seg_n)
  );

  // R8: a non-decimal digit leaves every segment dark
  assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_btn_n)
    (cur_digit > 4'd9) |-> seg_n == 7'h7F);

endmodule

// File: tb/digit_ring_display_tb_top.sv
module digit_ring_display_tb_top;

  logic clk = 1'b0;
  logic step_btn_n = 1'b1;
  logic rst_btn_n = 1'b0;
  logic dir_fwd = 1'b1;
  logic [6:0] seg_a, seg_b;

  always #10 clk = ~clk;

  int digs_a [5] = '{3, 9, 5, 0, 7};
  int digs_b [5] = '{2, 4, 12, 6, 15};
  int exp_pos = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  digit_ring_display dut_i (
    .clk(clk), .step_btn_n(step_btn_n), .rst_btn_n(rst_btn_n),
    .dir_fwd(dir_fwd), .seg_n(seg_a));

  digit_ring_display #(.DIG0(4'd2), .DIG1(4'd4), .DIG2(4'd12),
                       .DIG3(4'd6), .DIG4(4'd15)) dut_b (
    .clk(clk), .step_btn_n(step_btn_n), .rst_btn_n(rst_btn_n),
    .dir_fwd(dir_fwd), .seg_n(seg_b));

  // Active-low pattern, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] model_seg(input int d);
    logic [6:0] on;
    case (d)
      0: on = {1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1};
      1: on = {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0};
      2: on = {1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1};
      3: on = {1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1};
      4: on = {1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0};
      5: on = {1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1};
      6: on = {1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1};
      7: on = {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1};
      8: on = 7'b1111111;
      9: on = {1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1};
      default: on = 7'b0000000;
    endcase
    return ~on;
  endfunction

  function automatic int model_step(input int p, input bit fwd);
    return fwd ? (p + 1) % 5 : (p + 4) % 5;
  endfunction

  task automatic check_pos(input string req, input int p);
    n_chk++;
    if (seg_a !== model_seg(digs_a[p])) begin
      n_bad++;
      $display("FAIL %s dut_i: seg_n=%b expected %b (pos %0d)", req, seg_a, model_seg(digs_a[p]), p);
    end
    n_chk++;
    if (seg_b !== model_seg(digs_b[p])) begin
      n_bad++;
      $display("FAIL %s dut_b: seg_n=%b expected %b (pos %0d)", req, seg_b, model_seg(digs_b[p]), p);
    end
  endtask

  task automatic do_reset(input bit dir);
    @(negedge clk);
    dir_fwd = dir;
    rst_btn_n = 1'b0;
    @(negedge clk);
    exp_pos = 0;
    check_pos("R1", exp_pos);
    rst_btn_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Press held for 'hold' edges (>=3), latency checked on edges k, k+1, k+2
  task automatic press(input bit dir, input int hold);
    @(negedge clk);
    dir_fwd = dir;
    step_btn_n = 1'b0;
    @(negedge clk);
    check_pos("R6", exp_pos);
    @(negedge clk);
    check_pos("R6", exp_pos);
    @(negedge clk);
    exp_pos = model_step(exp_pos, dir);
    check_pos(dir ? "R2" : "R3", exp_pos);
    repeat (hold - 3) @(negedge clk);
    check_pos("R5", exp_pos);
    step_btn_n = 1'b1;
    if ($urandom_range(1, 0) == 1) dir_fwd = ~dir_fwd;
    repeat (4) @(negedge clk);
    check_pos("R5", exp_pos);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_btn_n = 1'b1;
    @(negedge clk);
    check_pos("R1", 0);

    // R2: full forward lap with wrap
    for (int i = 0; i < 6; i++) press(1'b1, 3);
    // R3: backward order d0,d4,d3,d2,d1,d0
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) press(1'b0, 4);
    // R4: mixed direction walk: fwd x4, bwd x2, fwd x4
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) press(1'b1, 3);
    for (int i = 0; i < 2; i++) press(1'b0, 3);
    for (int i = 0; i < 4; i++) press(1'b1, 3);
    check_pos("R4", exp_pos);
    // R5: long hold gives a single step
    press(1'b1, 40);

    // R7: advance event coincides with reset, button held past reset release
    press(1'b1, 3);
    @(negedge clk);
    step_btn_n = 1'b0;
    dir_fwd = 1'b1;
    @(negedge clk);
    rst_btn_n = 1'b0;
    repeat (2) @(negedge clk);
    exp_pos = 0;
    check_pos("R7", exp_pos);
    rst_btn_n = 1'b1;
    repeat (5) @(negedge clk);
    check_pos("R7", exp_pos);
    step_btn_n = 1'b1;
    repeat (4) @(negedge clk);
    check_pos("R7", exp_pos);

    // R1: reset with backward direction still lands on first digit
    press(1'b0, 3);
    do_reset(1'b0);

    // R8 and R4: random walk, dut_b exercises the blank code at position 2 and 4
    for (int i = 0; i < 300; i++) begin
      press(1'($urandom_range(1, 0)), int'($urandom_range(10, 3)));
      if ($urandom_range(40, 0) == 0) do_reset(1'($urandom_range(1, 0)));
    end
    check_pos("R8", exp_pos);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule